// File: doc/BRIEF.md
# Paired Byte FIFOs with Word-Sized Access and Level Requests

This block buffers data between a 32-bit register-bus side and a serial shift engine. It holds two byte-wide queues of four entries each, one for the transmit direction and one for the receive direction. Every access moves a whole serial word in a single cycle. A word is 1 to 32 bits long, and an access carries between one and four bytes of it, as the configured word length requires. Bytes sit in the queue least significant first, so the shift engine and the bus both see whole words, however many entries each word uses.

Each queue compares its fill level with a programmable threshold. The transmit side requests service when it has drained to its threshold or below. The receive side requests service when it has filled to its threshold or above. Each of the four outputs (transmit DMA, transmit interrupt, receive DMA, receive interrupt) has its own enable. A bus push that does not fit sets a sticky overflow flag. A bus pop that finds too few bytes sets a sticky underflow flag. A write-one pulse clears each flag. A synchronous flush input empties both queues.

Top module: `spi_byte_fifo_pair`

## Requirements
- R1: `wlen_m1_i` holds the word length minus one. Every access moves floor(wlen_m1_i/8)+1 bytes: 0..7 gives 1 byte, 8..15 gives 2, 16..23 gives 3 and 24..31 gives 4.
- R2: A pushed word is stored least significant byte first. A word read out has byte i (bits 8i+7..8i) equal to the i-th oldest entry for each i below the byte count, and all higher bits zero. The read-out value is only defined while the queue holds at least that many bytes.
- R3: A push is accepted only when the number of free entries is at least the byte count. The transmit level then rises by the byte count at the next clock edge. A bus push that does not fit leaves the queue unchanged and sets `ovf_o`.
- R4: A pop is accepted only when the level is at least the byte count. A bus receive pop that finds too few bytes leaves the queue unchanged and sets `unf_o`.
- R5: `ovf_o` and `unf_o` stay set until a cycle with their clear input high. When a set and a clear arrive in the same cycle, the flag ends up set.
- R6: `tx_dma_req_o` equals `tx_dma_en_i` AND (transmit level <= `tx_thr_i`). `tx_irq_o` follows the same rule with `tx_irq_en_i`.
- R7: `rx_dma_req_o` equals `rx_dma_en_i` AND (receive level >= `rx_thr_i`). `rx_irq_o` follows the same rule with `rx_irq_en_i`.
- R8: A cycle with `flush_i` high leaves both levels at zero after the edge. It discards that cycle's accesses and sets no flag.
- R9: After reset, both levels are zero and both flags are clear.
- R10: `eng_tx_avail_o` shows that the transmit queue holds a whole word. `eng_rx_space_o` shows that the receive queue can take one. A shift-engine access made while its indication is low is ignored and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Empty both queues |
| wlen_m1_i | input | 5 | Word length minus one |
| bus_tx_wr_i | input | 1 | Bus pushes a word into the transmit queue |
| bus_tx_wdata_i | input | 32 | Bus word to transmit |
| bus_rx_rd_i | input | 1 | Bus pops a word from the receive queue |
| bus_rx_rdata_o | output | 32 | Oldest receive word |
| eng_tx_pop_i | input | 1 | Shift engine takes a transmit word |
| eng_tx_word_o | output | 32 | Oldest transmit word |
| eng_tx_avail_o | output | 1 | A whole transmit word is present |
| eng_rx_push_i | input | 1 | Shift engine delivers a received word |
| eng_rx_word_i | input | 32 | Received word |
| eng_rx_space_o | output | 1 | Room for a whole received word |
| tx_thr_i | input | 3 | Transmit level threshold |
| rx_thr_i | input | 3 | Receive level threshold |
| tx_dma_en_i | input | 1 | Enable transmit DMA request |
| tx_irq_en_i | input | 1 | Enable transmit interrupt |
| rx_dma_en_i | input | 1 | Enable receive DMA request |
| rx_irq_en_i | input | 1 | Enable receive interrupt |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_dma_req_o | output | 1 | Receive DMA request |
| rx_irq_o | output | 1 | Receive interrupt |
| tx_level_o | output | 3 | Transmit fill level in bytes |
| rx_level_o | output | 3 | Receive fill level in bytes |
| ovf_o | output | 1 | Sticky transmit overflow |
| unf_o | output | 1 | Sticky receive underflow |
| ovf_clr_i | input | 1 | Clear overflow |
| unf_clr_i | input | 1 | Clear underflow |

## Verification
A wrong pointer or count shows up in the next cycle after the edge. It appears as a level output that differs from the byte count of the accesses accepted so far, and in the same cycle as a request output that flips against its threshold. A write pointer that skips or wraps wrongly stays hidden until the affected bytes reach the head. It then shows as a misordered or stale byte in the word read out, which can be up to three accesses later. A broken flag appears one edge after the rejected access, or as a flag that drops without its clear.

// File: rtl/spi_bf_pkg.sv
package spi_bf_pkg;

  // Bytes occupied by one serial word, given its length minus one.
  function automatic int unsigned bytes_per_word(input int unsigned wlen_m1);
    return (wlen_m1 / 8) + 1;
  endfunction

endpackage

// File: rtl/spi_bf_rst_sync.sv
module spi_bf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/spi_bf_byte_fifo.sv
module spi_bf_byte_fifo #(
  parameter  int DEPTH      = 4,
  parameter  int WORD_BYTES = 4,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int LVL_W      = $clog2(DEPTH + 1),
  localparam int NB_W       = $clog2(WORD_BYTES + 1),
  localparam int DATA_W     = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              push_ok_o,
  output logic              pop_ok_o
);

  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       push_bytes [DEPTH];
  logic [DEPTH-1:0] mem_we;
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic             fits, enough, push_do, pop_do;

  // Next-state logic for pointers and fill count.
  always_comb begin
    fits    = (DEPTH - int'(cnt_q)) >= int'(nbytes_i);
    enough  = int'(cnt_q) >= int'(nbytes_i);
    push_do = push_i & fits & ~flush_i;
    pop_do  = pop_i & enough & ~flush_i;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_do) begin
        wr_d = wr_q + PTR_W'(nbytes_i);
      end
      if (pop_do) begin
        rd_d = rd_q + PTR_W'(nbytes_i);
      end
      cnt_d = LVL_W'(int'(cnt_q) + (push_do ? int'(nbytes_i) : 0)
                                 - (pop_do  ? int'(nbytes_i) : 0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage: each entry takes the byte whose distance from the write pointer matches.
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [PTR_W-1:0] off;
    if (e < WORD_BYTES) begin : g_src
      assign push_bytes[e] = push_data_i[e*8 +: 8];
    end else begin : g_pad
      assign push_bytes[e] = 8'h00;
    end
    assign off       = PTR_W'(e) - wr_q;
    assign mem_we[e] = push_do && (int'(off) < int'(nbytes_i));
    always_ff @(posedge clk) begin
      if (mem_we[e]) begin
        mem_q[e] <= push_bytes[off];
      end
    end
  end

  // Head word, least significant byte first, zero above the byte count.
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_rd
    logic [PTR_W-1:0] ridx;
    assign ridx = rd_q + PTR_W'(k);
    assign pop_data_o[k*8 +: 8] = (k < int'(nbytes_i)) ? mem_q[ridx] : 8'h00;
  end

  assign level_o   = cnt_q;
  assign push_ok_o = fits;
  assign pop_ok_o  = enough;

endmodule

// File: rtl/spi_bf_level_cmp.sv
module spi_bf_level_cmp #(
  parameter int LVL_W      = 3,
  parameter bit FILL_ALARM = 1'b0
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  input  logic             dma_en_i,
  input  logic             irq_en_i,
  output logic             dma_o,
  output logic             irq_o
);

  logic hit;

  if (FILL_ALARM) begin : g_fill
    assign hit = level_i >= thr_i;
  end else begin : g_drain
    assign hit = level_i <= thr_i;
  end

  assign dma_o = dma_en_i & hit;
  assign irq_o = irq_en_i & hit;

endmodule

// File: rtl/spi_bf_sticky.sv
module spi_bf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/spi_byte_fifo_pair.sv
module spi_byte_fifo_pair #(
  parameter  int DEPTH      = 4,
  parameter  int WORD_BYTES = 4,
  localparam int DATA_W     = WORD_BYTES * 8,
  localparam int WL_W       = $clog2(DATA_W),
  localparam int LVL_W      = $clog2(DEPTH + 1),
  localparam int NB_W       = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [WL_W-1:0]   wlen_m1_i,
  input  logic              bus_tx_wr_i,
  input  logic [DATA_W-1:0] bus_tx_wdata_i,
  input  logic              bus_rx_rd_i,
  output logic [DATA_W-1:0] bus_rx_rdata_o,
  input  logic              eng_tx_pop_i,
  output logic [DATA_W-1:0] eng_tx_word_o,
  output logic              eng_tx_avail_o,
  input  logic              eng_rx_push_i,
  input  logic [DATA_W-1:0] eng_rx_word_i,
  output logic              eng_rx_space_o,
  input  logic [LVL_W-1:0]  tx_thr_i,
  input  logic [LVL_W-1:0]  rx_thr_i,
  input  logic              tx_dma_en_i,
  input  logic              tx_irq_en_i,
  input  logic              rx_dma_en_i,
  input  logic              rx_irq_en_i,
  output logic              tx_dma_req_o,
  output logic              tx_irq_o,
  output logic              rx_dma_req_o,
  output logic              rx_irq_o,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              ovf_o,
  output logic              unf_o,
  input  logic              ovf_clr_i,
  input  logic              unf_clr_i
);

  logic            rst_q_n;
  logic [NB_W-1:0] nbytes;
  logic            tx_push_ok, rx_pop_ok;
  logic            ovf_set, unf_set;

  spi_bf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign nbytes = NB_W'(spi_bf_pkg::bytes_per_word(int'(wlen_m1_i)));

  spi_bf_byte_fifo #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) u_txq (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .flush_i     (flush_i),
    .nbytes_i    (nbytes),
    .push_i      (bus_tx_wr_i),
    .push_data_i (bus_tx_wdata_i),
    .pop_i       (eng_tx_pop_i),
    .pop_data_o  (eng_tx_word_o),
    .level_o     (tx_level_o),
    .push_ok_o   (tx_push_ok),
    .pop_ok_o    (eng_tx_avail_o)
  );

  spi_bf_byte_fifo #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) u_rxq (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .flush_i     (flush_i),
    .nbytes_i    (nbytes),
    .push_i      (eng_rx_push_i),
    .push_data_i (eng_rx_word_i),
    .pop_i       (bus_rx_rd_i),
    .pop_data_o  (bus_rx_rdata_o),
    .level_o     (rx_level_o),
    .push_ok_o   (eng_rx_space_o),
    .pop_ok_o    (rx_pop_ok)
  );

  spi_bf_level_cmp #(.LVL_W(LVL_W), .FILL_ALARM(1'b0)) u_tx_cmp (
    .level_i  (tx_level_o),
    .thr_i    (tx_thr_i),
    .dma_en_i (tx_dma_en_i),
    .irq_en_i (tx_irq_en_i),
    .dma_o    (tx_dma_req_o),
    .irq_o    (tx_irq_o)
  );

  spi_bf_level_cmp #(.LVL_W(LVL_W), .FILL_ALARM(1'b1)) u_rx_cmp (
    .level_i  (rx_level_o),
    .thr_i    (rx_thr_i),
    .dma_en_i (rx_dma_en_i),
    .irq_en_i (rx_irq_en_i),
    .dma_o    (rx_dma_req_o),
    .irq_o    (rx_irq_o)
  );

  assign ovf_set = bus_tx_wr_i & ~tx_push_ok & ~flush_i;
  assign unf_set = bus_rx_rd_i & ~rx_pop_ok & ~flush_i;

  spi_bf_sticky u_ovf (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (ovf_set),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_o)
  );

  spi_bf_sticky u_unf (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (unf_set),
    .clr_i  (unf_clr_i),
    .flag_o (unf_o)
  );

endmodule

// File: rtl/spi_bf_chk.sv
module spi_bf_chk #(
  parameter  int DEPTH      = 4,
  parameter  int WORD_BYTES = 4,
  localparam int DATA_W     = WORD_BYTES * 8,
  localparam int WL_W       = $clog2(DATA_W),
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             flush_i,
  input logic [WL_W-1:0]  wlen_m1_i,
  input logic             bus_tx_wr_i,
  input logic             eng_tx_pop_i,
  input logic             bus_rx_rd_i,
  input logic             eng_rx_push_i,
  input logic             tx_irq_en_i,
  input logic             rx_dma_en_i,
  input logic             tx_irq_o,
  input logic             rx_dma_req_o,
  input logic [LVL_W-1:0] tx_level_o,
  input logic [LVL_W-1:0] rx_level_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             ovf_clr_i
);

  int nb;
  assign nb = int'(spi_bf_pkg::bytes_per_word(int'(wlen_m1_i)));

  // R3: the levels never exceed the depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (int'(tx_level_o) <= DEPTH) && (int'(rx_level_o) <= DEPTH));

  // R3: a fitting push raises the level by the byte count
  p_push_adds_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_tx_wr_i && !flush_i && !eng_tx_pop_i && (DEPTH - int'(tx_level_o)) >= nb)
    |=> (int'(tx_level_o) == int'($past(tx_level_o)) + $past(nb)));

  // R3: a push that does not fit leaves the queue and raises overflow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_tx_wr_i && !flush_i && !eng_tx_pop_i && (DEPTH - int'(tx_level_o)) < nb)
    |=> ($stable(tx_level_o) && ovf_o));

  // R4: a pop short of bytes leaves the queue and raises underflow
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_rx_rd_i && !flush_i && !eng_rx_push_i && int'(rx_level_o) < nb)
    |=> ($stable(rx_level_o) && unf_o));

  // R5: overflow holds without a clear
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R6: transmit interrupt silent while disabled
  p_tx_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    !tx_irq_en_i |-> !tx_irq_o);

  // R7: receive DMA request silent while disabled
  p_rx_dma_gate_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !rx_dma_en_i |-> !rx_dma_req_o);

  // R8: flush empties both queues
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    flush_i |=> (tx_level_o == '0 && rx_level_o == '0));

endmodule

bind spi_byte_fifo_pair spi_bf_chk #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_q_n),
  .flush_i      (flush_i),
  .wlen_m1_i    (wlen_m1_i),
  .bus_tx_wr_i  (bus_tx_wr_i),
  .eng_tx_pop_i (eng_tx_pop_i),
  .bus_rx_rd_i  (bus_rx_rd_i),
  .eng_rx_push_i(eng_rx_push_i),
  .tx_irq_en_i  (tx_irq_en_i),
  .rx_dma_en_i  (rx_dma_en_i),
  .tx_irq_o     (tx_irq_o),
  .rx_dma_req_o (rx_dma_req_o),
  .tx_level_o   (tx_level_o),
  .rx_level_o   (rx_level_o),
  .ovf_o        (ovf_o),
  .unf_o        (unf_o),
  .ovf_clr_i    (ovf_clr_i)
);

// File: tb/sim_spi_byte_fifo_pair.sv
`timescale 1ns/1ps
module sim_spi_byte_fifo_pair;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic [4:0]  wlen_m1_i;
  logic        bus_tx_wr_i;
  logic [31:0] bus_tx_wdata_i;
  logic        bus_rx_rd_i;
  logic [31:0] bus_rx_rdata_o;
  logic        eng_tx_pop_i;
  logic [31:0] eng_tx_word_o;
  logic        eng_tx_avail_o;
  logic        eng_rx_push_i;
  logic [31:0] eng_rx_word_i;
  logic        eng_rx_space_o;
  logic [2:0]  tx_thr_i, rx_thr_i;
  logic        tx_dma_en_i, tx_irq_en_i, rx_dma_en_i, rx_irq_en_i;
  logic        tx_dma_req_o, tx_irq_o, rx_dma_req_o, rx_irq_o;
  logic [2:0]  tx_level_o, rx_level_o;
  logic        ovf_o, unf_o, ovf_clr_i, unf_clr_i;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit m_ovf, m_unf;

  always #10 clk = ~clk;

  spi_byte_fifo_pair u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] head_word(input logic [7:0] q[$], input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) w[i*8 +: 8] = q[i];
    return w;
  endfunction

  function automatic int nbytes_of(input logic [4:0] wl);
    return int'(wl) / 8 + 1;
  endfunction

  task automatic idle();
    flush_i = 0; bus_tx_wr_i = 0; bus_rx_rd_i = 0; eng_tx_pop_i = 0;
    eng_rx_push_i = 0; ovf_clr_i = 0; unf_clr_i = 0;
  endtask

  // Called just after a falling edge with inputs set; returns at the next falling edge.
  task automatic cycle();
    int n;
    bit tok, tfit, rok, rfit, set_o, set_u;
    #2;
    n    = nbytes_of(wlen_m1_i);
    tok  = txq.size() >= n;
    tfit = (4 - txq.size()) >= n;
    rok  = rxq.size() >= n;
    rfit = (4 - rxq.size()) >= n;
    chk("R10 tx_avail", {31'b0, eng_tx_avail_o}, {31'b0, tok});
    chk("R10 rx_space", {31'b0, eng_rx_space_o}, {31'b0, rfit});
    if (tok) chk("R2 R1 tx word", eng_tx_word_o, head_word(txq, n));
    if (rok) chk("R2 R1 rx word", bus_rx_rdata_o, head_word(rxq, n));
    chk("R6 tx dma", {31'b0, tx_dma_req_o}, {31'b0, tx_dma_en_i && (txq.size() <= int'(tx_thr_i))});
    chk("R6 tx irq", {31'b0, tx_irq_o},     {31'b0, tx_irq_en_i && (txq.size() <= int'(tx_thr_i))});
    chk("R7 rx dma", {31'b0, rx_dma_req_o}, {31'b0, rx_dma_en_i && (rxq.size() >= int'(rx_thr_i))});
    chk("R7 rx irq", {31'b0, rx_irq_o},     {31'b0, rx_irq_en_i && (rxq.size() >= int'(rx_thr_i))});
    set_o = bus_tx_wr_i && !flush_i && !tfit;
    set_u = bus_rx_rd_i && !flush_i && !rok;
    m_ovf = set_o || (m_ovf && !ovf_clr_i);
    m_unf = set_u || (m_unf && !unf_clr_i);
    if (flush_i) begin
      txq.delete();
      rxq.delete();
    end else begin
      if (eng_tx_pop_i && tok) repeat (n) void'(txq.pop_front());
      if (bus_tx_wr_i && tfit) for (int i = 0; i < n; i++) txq.push_back(bus_tx_wdata_i[i*8 +: 8]);
      if (bus_rx_rd_i && rok) repeat (n) void'(rxq.pop_front());
      if (eng_rx_push_i && rfit) for (int i = 0; i < n; i++) rxq.push_back(eng_rx_word_i[i*8 +: 8]);
    end
    @(posedge clk);
    #2;
    chk("R1 R3 R4 R8 tx level", {29'b0, tx_level_o}, txq.size());
    chk("R1 R3 R4 R8 rx level", {29'b0, rx_level_o}, rxq.size());
    chk("R3 R5 ovf", {31'b0, ovf_o}, {31'b0, m_ovf});
    chk("R4 R5 unf", {31'b0, unf_o}, {31'b0, m_unf});
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 0;
    idle();
    wlen_m1_i = '0; bus_tx_wdata_i = '0; eng_rx_word_i = '0;
    tx_thr_i = 3'd2; rx_thr_i = 3'd1;
    tx_dma_en_i = 1; tx_irq_en_i = 1; rx_dma_en_i = 1; rx_irq_en_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #2;
    chk("R9 tx level", {29'b0, tx_level_o}, 0);
    chk("R9 rx level", {29'b0, rx_level_o}, 0);
    chk("R9 ovf", {31'b0, ovf_o}, 0);
    chk("R9 unf", {31'b0, unf_o}, 0);
    @(negedge clk);

    // Four-byte word fills the transmit queue (R1 R3)
    wlen_m1_i = 5'd31; bus_tx_wr_i = 1; bus_tx_wdata_i = 32'h44332211; cycle();
    // One more byte does not fit: overflow (R3)
    wlen_m1_i = 5'd7; bus_tx_wdata_i = 32'h00000055; cycle();
    // Clear and set together: set wins (R5)
    ovf_clr_i = 1; cycle();
    // Plain clear (R5)
    idle(); ovf_clr_i = 1; cycle();
    // Engine pops a 16-bit word: 0x2211 (R2)
    idle(); wlen_m1_i = 5'd15; eng_tx_pop_i = 1; cycle();
    idle(); chk("R2 remaining head", eng_tx_word_o, 32'h00004433);
    // Underflow on empty receive queue (R4)
    wlen_m1_i = 5'd23; bus_rx_rd_i = 1; cycle();
    // Engine pushes three bytes (R1)
    idle(); wlen_m1_i = 5'd23; eng_rx_push_i = 1; eng_rx_word_i = 32'hA0B0C0D0; cycle();
    // Engine push with too little room is dropped, no flag (R10)
    cycle();
    idle(); wlen_m1_i = 5'd7; bus_rx_rd_i = 1; unf_clr_i = 1; cycle();
    // Flush with a push in the same cycle (R8)
    idle(); flush_i = 1; bus_tx_wr_i = 1; cycle();
    idle(); #2;
    chk("R8 tx empty", {29'b0, tx_level_o}, 0);
    chk("R8 rx empty", {29'b0, rx_level_o}, 0);
    @(negedge clk);

    for (int it = 0; it < 3000; it++) begin
      idle();
      wlen_m1_i      = 5'($urandom_range(0, 31));
      bus_tx_wr_i    = ($urandom_range(0, 99) < 45);
      bus_tx_wdata_i = $urandom;
      eng_tx_pop_i   = ($urandom_range(0, 99) < 35);
      eng_rx_push_i  = ($urandom_range(0, 99) < 45);
      eng_rx_word_i  = $urandom;
      bus_rx_rd_i    = ($urandom_range(0, 99) < 35);
      flush_i        = ($urandom_range(0, 99) < 3);
      ovf_clr_i      = ($urandom_range(0, 99) < 10);
      unf_clr_i      = ($urandom_range(0, 99) < 10);
      tx_thr_i       = 3'($urandom_range(0, 4));
      rx_thr_i       = 3'($urandom_range(0, 4));
      tx_dma_en_i    = $urandom_range(0, 1);
      tx_irq_en_i    = $urandom_range(0, 1);
      rx_dma_en_i    = $urandom_range(0, 1);
      rx_irq_en_i    = $urandom_range(0, 1);
      cycle();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule